// File: doc/BRIEF.md
# Bus Request Legality Checker with Register Target

This block sits on the request channel of a TL-UL device. Each incoming request is sorted into legal or illegal. The checks cover protocol rules (opcode, size, lane mask, alignment) and rules for the device's register space (full-width aligned register writes, access permission, unmapped addresses). The verdict travels back on the response channel as an error flag. An illegal write never reaches the registers.

A small map of four 32-bit-slot registers sits behind the checker, so the effect of each verdict can be seen through ordinary reads and writes. The map is:

| Offset | Access | Width |
|---|---|---|
| 0x00 | read-write | 4 bytes |
| 0x04 | read-write | 2 bytes |
| 0x08 | read-only, fixed value 32'h1234_ABCD | 4 bytes |
| 0x0C | write-only | 4 bytes |

Every other word address in the 8-bit space is unmapped. The device accepts one request at a time. It answers in the cycle after acceptance and holds the answer until the requester takes it.

Top module: `bus_req_guard`

## Requirements
- R1: Legal request opcodes are PutFullData (0), PutPartialData (1) and Get (4); any other opcode is answered with d_error=1. A Get is answered with response opcode 1 (data acknowledge), and every other request is answered with response opcode 0.
- R2: A request whose size field is 3 is answered with d_error=1.
- R3: A request whose address is not a multiple of 2^size is answered with d_error=1.
- R4: The active lanes of a request are the 2^size lanes starting at lane address[1:0]. A mask bit set outside the active lanes gives d_error=1, for example size 0, address 0 with mask 4'b0010, or size 0, address 1 with mask 4'b0001.
- R5: A PutFullData request whose mask is not exactly its set of active lanes is answered with d_error=1.
- R6: An access to an unmapped address gets d_error=1 only while dev_mode=1. While dev_mode=0 it gets d_error=0, a write to it has no effect, and a read of it returns 0.
- R7: A write to a mapped register is an error if address[1:0] is not 0. It is also an error if the mask does not set every lane below the register's byte width.
- R8: A Get of the write-only register, or a write of the read-only register, is answered with d_error=1. The read-only register always reads 32'h1234_ABCD.
- R9: An erroneous write changes no register. An erroneous Get returns d_data of all ones.
- R10: A legal write stores the enabled lanes that lie within the register's width. Lanes beyond the width read as 0. A legal Get returns the full register word, and a write response carries d_data=0.
- R11: a_ready is low whenever a response is pending. A response appears on the cycle after acceptance and its fields stay unchanged until d_ready is seen.
- R12: After reset d_valid=0, a_ready=1, and the read-write and write-only registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_mode | input | 1 | Unmapped accesses are reported as errors while high |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Request accepted when high together with a_valid |
| a_opcode | input | 3 | Request opcode |
| a_size | input | 2 | Log2 of the transfer size in bytes |
| a_address | input | ADDR_W | Byte address |
| a_mask | input | 4 | Byte-lane enables |
| a_data | input | 32 | Write data |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Response taken when high together with d_valid |
| d_opcode | output | 3 | Response opcode: 0 acknowledge, 1 acknowledge with data |
| d_error | output | 1 | Request was illegal |
| d_data | output | 32 | Read data |

## Verification
The assertions watch the handshake on every cycle. They check that a_ready stays low while a response waits, that a response follows each acceptance, and that a held response is stable. They also check the verdicts that can be read straight from the request fields: bad opcodes, oversize requests, misaligned word accesses, incomplete PutFullData masks, the response opcode for Get, and all-ones data on a failed read. Only the bench's scenarios can show the map-dependent rules: partial-width register writes, permission faults, unmapped addresses under both dev_mode settings, and the rule that a rejected write really leaves register contents unchanged. The bench shows these by reading registers back after each stimulus.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int NUM_REGS  = 4;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam logic [DATA_W-1:0] RO_VALUE = 32'h1234_ABCD;

    typedef enum logic [2:0] {
        A_PUT_FULL = 3'd0,
        A_PUT_PART = 3'd1,
        A_GET      = 3'd4
    } a_opc_e;

    typedef enum logic [2:0] {
        D_ACK      = 3'd0,
        D_ACK_DATA = 3'd1
    } d_opc_e;

    typedef enum logic [1:0] {
        K_RW = 2'd0,
        K_RO = 2'd1,
        K_WO = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic                 err;
        logic                 is_read;
        logic                 is_write;
        logic                 hit;
        logic [REG_IDX_W-1:0] idx;
    } verdict_t;

    function automatic reg_kind_e reg_kind(input int i);
        case (i)
            2:       return K_RO;
            3:       return K_WO;
            default: return K_RW;
        endcase
    endfunction

    function automatic int reg_bytes(input int i);
        return (i == 1) ? 2 : LANES;
    endfunction

    function automatic logic [LANES-1:0] width_lanes(input int i);
        return LANES'((1 << reg_bytes(i)) - 1);
    endfunction

    function automatic logic [LANES-1:0] active_lanes(input logic [1:0] size,
                                                      input logic [1:0] lo);
        case (size)
            2'd0:    return LANES'(4'b0001 << lo);
            2'd1:    return LANES'(4'b0011 << lo);
            2'd2:    return 4'b1111;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bus_req_classify.sv
module bus_req_classify
    import bus_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [2:0]        opcode,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  mask,
    input  logic              dev_mode,
    output verdict_t          verdict
);
    localparam int WORD_W = ADDR_W - 2;

    logic                 legal_opc;
    logic                 misalign;
    logic                 mask_out;
    logic                 full_miss;
    logic                 proto_err;
    logic                 map_err;
    logic [LANES-1:0]     lanes;
    logic [LANES-1:0]     need;
    logic                 hit;
    logic [REG_IDX_W-1:0] idx;
    reg_kind_e            kind;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr[ADDR_W-1:2] == WORD_W'(i)) begin
                hit = 1'b1;
                idx = REG_IDX_W'(i);
            end
        end
    end

    always_comb begin
        legal_opc = (opcode == A_PUT_FULL) || (opcode == A_PUT_PART) || (opcode == A_GET);
        lanes     = active_lanes(size, addr[1:0]);
        misalign  = ((size == 2'd1) && addr[0]) || ((size == 2'd2) && (addr[1:0] != 2'd0));
        mask_out  = |(mask & ~lanes);
        full_miss = (opcode == A_PUT_FULL) && (mask != lanes);
        proto_err = !legal_opc || (size == 2'd3) || misalign || mask_out || full_miss;
        kind      = reg_kind(int'(idx));
        need      = width_lanes(int'(idx));
    end

    always_comb begin
        verdict.is_read  = (opcode == A_GET);
        verdict.is_write = (opcode == A_PUT_FULL) || (opcode == A_PUT_PART);
        verdict.hit      = hit;
        verdict.idx      = idx;
        map_err = 1'b0;
        if (!hit) begin
            map_err = dev_mode;
        end else begin
            if (verdict.is_write && ((addr[1:0] != 2'd0) || ((mask & need) != need)))
                map_err = 1'b1;
            if (verdict.is_write && (kind == K_RO))
                map_err = 1'b1;
            if (verdict.is_read && (kind == K_WO))
                map_err = 1'b1;
        end
        verdict.err = proto_err || map_err;
    end

endmodule

// File: rtl/bus_req_regfile.sv
module bus_req_regfile
    import bus_guard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0]     wr_mask,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam reg_kind_e KIND = reg_kind(i);
        localparam int        NB   = reg_bytes(i);

        if (KIND == K_RO) begin : g_const
            assign words[i] = RO_VALUE;
        end else begin : g_store
            logic [NB*8-1:0] q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == REG_IDX_W'(i))) begin
                    for (int b = 0; b < NB; b++) begin
                        if (wr_mask[b]) q[b*8 +: 8] <= wr_data[b*8 +: 8];
                    end
                end
            end

            if (NB < LANES) begin : g_pad
                assign words[i] = {{(DATA_W - NB*8){1'b0}}, q};
            end else begin : g_full
                assign words[i] = q;
            end
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/bus_req_resp.sv
module bus_req_resp
    import bus_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2:0]        ld_opcode,
    input  logic              ld_error,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              d_ready,
    output logic              d_valid,
    output logic [2:0]        d_opcode,
    output logic              d_error,
    output logic [DATA_W-1:0] d_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid  <= 1'b0;
            d_opcode <= D_ACK;
            d_error  <= 1'b0;
            d_data   <= '0;
        end else if (load) begin
            d_valid  <= 1'b1;
            d_opcode <= ld_opcode;
            d_error  <= ld_error;
            d_data   <= ld_data;
        end else if (d_valid && d_ready) begin
            d_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_req_guard.sv
module bus_req_guard
    import bus_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_mode,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [2:0]        a_opcode,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] a_address,
    input  logic [3:0]        a_mask,
    input  logic [31:0]       a_data,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [2:0]        d_opcode,
    output logic              d_error,
    output logic [31:0]       d_data
);
    verdict_t          verdict;
    logic              accept;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rsp_data;
    logic [2:0]        rsp_opcode;

    bus_req_classify #(.ADDR_W(ADDR_W)) u_classify (
        .opcode   (a_opcode),
        .size     (a_size),
        .addr     (a_address),
        .mask     (a_mask),
        .dev_mode (dev_mode),
        .verdict  (verdict)
    );

    assign a_ready = !d_valid;
    assign accept  = a_valid && a_ready;
    assign wr_en   = accept && verdict.is_write && verdict.hit && !verdict.err;

    bus_req_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (verdict.idx),
        .wr_mask (a_mask),
        .wr_data (a_data),
        .rd_idx  (verdict.idx),
        .rd_data (rd_word)
    );

    always_comb begin
        rsp_opcode = verdict.is_read ? D_ACK_DATA : D_ACK;
        if (!verdict.is_read)  rsp_data = '0;
        else if (verdict.err)  rsp_data = '1;
        else if (verdict.hit)  rsp_data = rd_word;
        else                   rsp_data = '0;
    end

    bus_req_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .ld_opcode (rsp_opcode),
        .ld_error  (verdict.err),
        .ld_data   (rsp_data),
        .d_ready   (d_ready),
        .d_valid   (d_valid),
        .d_opcode  (d_opcode),
        .d_error   (d_error),
        .d_data    (d_data)
    );

endmodule

// File: rtl/bus_req_guard_chk.sv
module bus_req_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        a_valid,
    input logic        a_ready,
    input logic [2:0]  a_opcode,
    input logic [1:0]  a_size,
    input logic [1:0]  a_addr_lo,
    input logic [3:0]  a_mask,
    input logic        d_valid,
    input logic        d_ready,
    input logic [2:0]  d_opcode,
    input logic        d_error,
    input logic [31:0] d_data
);
    logic taken;
    assign taken = a_valid && a_ready;

    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !a_ready); // R11
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        taken |=> d_valid); // R11
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_opcode) && $stable(d_error) && $stable(d_data))); // R11
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (taken && !(a_opcode == 3'd0 || a_opcode == 3'd1 || a_opcode == 3'd4)) |=> d_error); // R1
    AST_GET_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (taken && a_opcode == 3'd4) |=> (d_opcode == 3'd1)); // R1
    AST_OVERSIZE: assert property (@(posedge clk) disable iff (rst)
        (taken && a_size == 2'd3) |=> d_error); // R2
    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (taken && a_size == 2'd2 && a_addr_lo != 2'd0) |=> d_error); // R3
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
        (taken && a_opcode == 3'd0 && a_size == 2'd2 && a_mask != 4'hF) |=> d_error); // R5
    AST_FAIL_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_error && d_opcode == 3'd1) |-> (d_data == 32'hFFFF_FFFF)); // R9

endmodule

bind bus_req_guard bus_req_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_valid   (a_valid),
    .a_ready   (a_ready),
    .a_opcode  (a_opcode),
    .a_size    (a_size),
    .a_addr_lo (a_address[1:0]),
    .a_mask    (a_mask),
    .d_valid   (d_valid),
    .d_ready   (d_ready),
    .d_opcode  (d_opcode),
    .d_error   (d_error),
    .d_data    (d_data)
);

// File: tb/bus_req_guard_test.sv
`timescale 1ns/1ps
module bus_req_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_mode = 1'b0;
    logic        a_valid = 1'b0;
    logic        a_ready;
    logic [2:0]  a_opcode = 3'd4;
    logic [1:0]  a_size = 2'd2;
    logic [7:0]  a_address = 8'd0;
    logic [3:0]  a_mask = 4'hF;
    logic [31:0] a_data = 32'd0;
    logic        d_valid;
    logic        d_ready = 1'b0;
    logic [2:0]  d_opcode;
    logic        d_error;
    logic [31:0] d_data;

    int errors = 0;
    int checks = 0;
    bit watching = 1'b0;
    bit exp_pending = 1'b0;
    bit finished = 1'b0;
    logic [31:0] mdl [4];
    int          wid [4] = '{4, 2, 4, 4};

    always #2 clk = ~clk;

    bus_req_guard uut (
        .clk(clk), .rst(rst), .dev_mode(dev_mode),
        .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_size(a_size),
        .a_address(a_address), .a_mask(a_mask), .a_data(a_data),
        .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
        .d_error(d_error), .d_data(d_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the handshake against the model's pending flag.
    always @(negedge clk) begin
        if (watching && !finished) begin
            check(d_valid === exp_pending, "R11 d_valid", 32'(d_valid), 32'(exp_pending));
            check(a_ready === !exp_pending, "R11 a_ready", 32'(a_ready), 32'(!exp_pending));
        end
    end

    function automatic bit model_err(input int opc, input int size, input int addr,
                                     input logic [3:0] mask, input bit dm);
        bit e = 0;
        int nb, lo, w;
        bit wr, rd;
        wr = (opc == 0) || (opc == 1);
        rd = (opc == 4);
        if (!wr && !rd) e = 1;
        if (size > 2) return 1;
        nb = 1 << size;
        lo = addr % 4;
        if ((addr % nb) != 0) e = 1;
        for (int l = 0; l < 4; l++) begin
            bit inside_l = (l >= lo) && (l < lo + nb);
            if (mask[l] && !inside_l) e = 1;
            if (opc == 0 && !mask[l] && inside_l) e = 1;
        end
        w = addr / 4;
        if (w >= 4) begin
            if (dm) e = 1;
        end else begin
            if (wr && lo != 0) e = 1;
            if (wr) for (int l = 0; l < wid[w]; l++) if (!mask[l]) e = 1;
            if (wr && w == 2) e = 1;
            if (rd && w == 3) e = 1;
        end
        return e;
    endfunction

    task automatic req(input int opc, input int size, input int addr, input logic [3:0] mask,
                       input logic [31:0] data, input bit dm, input int hold, input string tag);
        bit e;
        bit rd;
        int w;
        logic [31:0] edata;
        logic [2:0]  eopc;
        e  = model_err(opc, size, addr, mask, dm);
        rd = (opc == 4);
        w  = addr / 4;
        eopc = rd ? 3'd1 : 3'd0;
        if (!rd)         edata = 32'd0;
        else if (e)      edata = 32'hFFFF_FFFF;
        else if (w < 4)  edata = mdl[w];
        else             edata = 32'd0;
        @(negedge clk);
        a_valid = 1'b1; a_opcode = 3'(opc); a_size = 2'(size);
        a_address = 8'(addr); a_mask = mask; a_data = data; dev_mode = dm;
        @(posedge clk);
        exp_pending = 1'b1;
        if (!rd && !e && w < 4)
            for (int l = 0; l < wid[w]; l++) if (mask[l]) mdl[w][l*8 +: 8] = data[l*8 +: 8];
        @(negedge clk);
        check(d_error === e, {tag, " error"}, 32'(d_error), 32'(e));
        check(d_opcode === eopc, {tag, " opcode"}, 32'(d_opcode), 32'(eopc));
        check(d_data === edata, {tag, " data"}, d_data, edata);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(d_error === e && d_data === edata && d_opcode === eopc,
                  "R11 held", d_data, edata);
        end
        a_valid = 1'b0; d_ready = 1'b1;
        @(posedge clk);
        exp_pending = 1'b0;
        @(negedge clk);
        d_ready = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        mdl[0] = 0; mdl[1] = 0; mdl[2] = 32'h1234_ABCD; mdl[3] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: idle after reset
        check(a_ready === 1'b1, "R12 a_ready", 32'(a_ready), 1);
        check(d_valid === 1'b0, "R12 d_valid", 32'(d_valid), 0);
        watching = 1'b1;
        req(4, 2, 8'h00, 4'hF, 0, 0, 0, "R12 reg0 reset");
        req(4, 2, 8'h04, 4'hF, 0, 0, 0, "R12 reg1 reset");
        // R10: legal writes and readback
        req(0, 2, 8'h00, 4'hF, 32'hDEAD_BEEF, 1, 0, "R10 put full");
        req(4, 2, 8'h00, 4'hF, 0, 1, 0, "R10 readback");
        req(1, 2, 8'h04, 4'b0111, 32'hAABB_CCDD, 1, 0, "R10 partial within width");
        req(4, 2, 8'h04, 4'hF, 0, 1, 0, "R10 narrow readback");
        req(0, 1, 8'h04, 4'b0011, 32'h0000_1357, 1, 0, "R10 halfword put");
        req(4, 0, 8'h04, 4'b0001, 0, 1, 0, "R10 byte get full word");
        // R1: opcodes
        req(2, 2, 8'h00, 4'hF, 32'h1111_1111, 1, 0, "R1 opcode 2");
        req(5, 2, 8'h00, 4'hF, 0, 1, 0, "R1 opcode 5");
        req(7, 2, 8'h00, 4'hF, 32'h2222_2222, 1, 0, "R1 opcode 7");
        // R2
        req(4, 3, 8'h00, 4'hF, 0, 1, 0, "R2 size 3 get");
        req(0, 3, 8'h00, 4'hF, 32'h3333_3333, 1, 0, "R2 size 3 put");
        // R3
        req(4, 1, 8'h01, 4'b0010, 0, 1, 0, "R3 half misaligned");
        req(4, 2, 8'h02, 4'b1100, 0, 1, 0, "R3 word misaligned");
        req(4, 0, 8'h03, 4'b1000, 0, 1, 0, "R3 byte any offset");
        // R4
        req(4, 0, 8'h00, 4'b0010, 0, 1, 0, "R4 lane outside size");
        req(4, 0, 8'h01, 4'b0001, 0, 1, 0, "R4 lane vs offset");
        req(4, 1, 8'h02, 4'b0011, 0, 1, 0, "R4 half wrong lanes");
        // R5
        req(0, 2, 8'h00, 4'b0111, 32'h4444_4444, 1, 0, "R5 full missing lane");
        req(4, 2, 8'h00, 4'hF, 0, 1, 0, "R9 reg0 unchanged");
        // R6
        req(4, 2, 8'h40, 4'hF, 0, 1, 0, "R6 unmapped get devmode");
        req(4, 2, 8'h40, 4'hF, 0, 0, 0, "R6 unmapped get quiet");
        req(0, 2, 8'h10, 4'hF, 32'h5555_5555, 0, 0, "R6 unmapped put quiet");
        req(0, 2, 8'hFC, 4'hF, 32'h5555_5555, 1, 0, "R6 unmapped put devmode");
        req(4, 2, 8'h00, 4'hF, 0, 0, 0, "R6 reg0 untouched");
        // R7
        req(1, 2, 8'h00, 4'b0011, 32'h6666_6666, 1, 0, "R7 partial reg0");
        req(0, 0, 8'h04, 4'b0001, 32'h0000_0077, 1, 0, "R7 byte on halfword reg");
        req(0, 0, 8'h05, 4'b0010, 32'h0000_8800, 1, 0, "R7 low bits nonzero");
        req(4, 2, 8'h00, 4'hF, 0, 1, 0, "R9 reg0 after R7");
        req(4, 2, 8'h04, 4'hF, 0, 1, 0, "R9 reg1 after R7");
        // R8
        req(4, 2, 8'h0C, 4'hF, 0, 1, 0, "R8 get write-only");
        req(0, 2, 8'h08, 4'hF, 32'h9999_9999, 1, 0, "R8 put read-only");
        req(4, 2, 8'h08, 4'hF, 0, 1, 0, "R8 read-only value");
        req(0, 2, 8'h0C, 4'hF, 32'hCAFE_F00D, 1, 0, "R8 put write-only legal");
        // R11: held response with backpressure
        req(4, 2, 8'h00, 4'hF, 0, 1, 3, "R11 hold read");
        req(2, 2, 8'h00, 4'hF, 0, 1, 2, "R11 hold error");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule